// File: doc/BRIEF.md
# Jump Reorder Stage for Hardware Delayed Branching

This stage sits in the instruction fetch path between decode and issue. It keeps the most recent decoded instruction in a one-entry holding register and compares it with the next one. When the next instruction is a jump and the pair is independent, the stage sends the jump out first and keeps the earlier instruction. That instruction then issues in the cycle just after the jump and fills the jump's shadow slot, with no help from the compiler.

Each swap also produces a one-cycle write request that stores the reordered pair back into the instruction cache. Later fetches then find the jump already in front. Both rewritten words carry a marker bit, so a pair that has been reordered once is never reordered again.

Instructions enter and leave with valid/ready handshakes. An instruction leaves the holding register only when its successor is presented, because the swap decision needs both.

Top module: `jump_swap_stage`

## Requirements
- R1: While rst_ni is low and after its release, out_valid_o and wr_valid_o are 0 and in_ready_o is 1.
- R2: in_ready_o equals (holding register empty) OR out_ready_i. out_valid_o is 1 only when the holding register is full and in_valid_i is 1. Without a swap, the output is the held instruction with every field unchanged, and the incoming instruction replaces it on the handshake.
- R3: A swap occurs only under all of these conditions:
  - the incoming instruction is a jump;
  - the held instruction is not a jump;
  - neither instruction has its target flag set;
  - neither instruction has its marker set;
  - both lie in the same cache line;
  - they share no register.

  On a swap, the jump is output with the held instruction's pc and marker 1. The held instruction stays in the holding register with the jump's pc and marker 1, and is output next.
- R4: No swap occurs when the held instruction is a jump.
- R5: Registers are compared across all nine pairings of {rs1, rs2, rd} against {rs1, rs2, rd}. Any equal nonzero index blocks the swap. Index 0 never blocks it.
- R6: No swap occurs when pc[ADDR_W-1:$clog2(LINE_WORDS)] differs between the two instructions.
- R7: No swap occurs when either instruction has its branch-target flag set.
- R8: No swap occurs when either instruction already carries the marker bit.
- R9: In the cycle after a swap handshake, wr_valid_o is 1 for exactly one cycle, with the following contents:
  - wr_pc_lo_o is the held instruction's original pc, and wr_word_lo_o holds the jump;
  - wr_pc_hi_o is the jump's original pc, and wr_word_hi_o holds the held instruction.

  Each word is {marker=1, jump, rs1, rs2, rd}, with the marker as the MSB and rd in the LSBs. wr_valid_o is 0 in every other cycle.
- R10: While the holding register is full and out_ready_i is 0, in_ready_o is 0 and the held instruction is kept unchanged: nothing is dropped and nothing is duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming instruction valid |
| in_ready_o | output | 1 | Stage accepts an instruction |
| in_pc_i | input | ADDR_W | Word address of the incoming instruction |
| in_jump_i | input | 1 | Incoming instruction is a jump |
| in_tgt_i | input | 1 | Incoming instruction is a branch target |
| in_mark_i | input | 1 | Incoming instruction was already reordered |
| in_rs1_i | input | REG_W | First source register |
| in_rs2_i | input | REG_W | Second source register |
| in_rd_i | input | REG_W | Destination register |
| out_valid_o | output | 1 | Outgoing instruction valid |
| out_ready_i | input | 1 | Downstream accepts |
| out_pc_o | output | ADDR_W | Word address of the outgoing instruction |
| out_jump_o | output | 1 | Outgoing instruction is a jump |
| out_tgt_o | output | 1 | Outgoing branch-target flag |
| out_mark_o | output | 1 | Outgoing marker bit |
| out_rs1_o | output | REG_W | Outgoing first source |
| out_rs2_o | output | REG_W | Outgoing second source |
| out_rd_o | output | REG_W | Outgoing destination |
| wr_valid_o | output | 1 | Cache rewrite request |
| wr_pc_lo_o | output | ADDR_W | Slot receiving the jump |
| wr_word_lo_o | output | 2+3*REG_W | Jump word written to the low slot |
| wr_pc_hi_o | output | ADDR_W | Slot receiving the earlier instruction |
| wr_word_hi_o | output | 2+3*REG_W | Earlier instruction word written to the high slot |

## Verification
The assertions check on every cycle that the following hold:
- a stalled holding register keeps its contents;
- rewrite requests never come in consecutive cycles and always place a jump word low and a non-jump word high within one line;
- after a rewrite the held instruction is marked.

Whether each individual veto (shared register, register 0, line crossing, target flag, marker, predecessor jump) blocks or allows the swap, and whether the exact output order and pc exchange are right, can only be shown by the bench. It does so through directed pairs and a random stream compared against its own model.

// File: rtl/jump_swap_pkg.sv
package jump_swap_pkg;
  typedef enum logic [2:0] {
    SW_OK,
    SW_NOT_JUMP,
    SW_PRED_JUMP,
    SW_TARGET,
    SW_MARKED,
    SW_LINE,
    SW_REGS
  } swap_why_e;

  localparam int unsigned REGS_PER_INSN = 3;
endpackage

// File: rtl/reg_overlap.sv
module reg_overlap #(
  parameter int unsigned REG_W = 6
) (
  input  logic [jump_swap_pkg::REGS_PER_INSN-1:0][REG_W-1:0] a_i,
  input  logic [jump_swap_pkg::REGS_PER_INSN-1:0][REG_W-1:0] b_i,
  output logic                                               hit_o
);
  localparam int unsigned N = jump_swap_pkg::REGS_PER_INSN;

  logic [N*N-1:0] pair_hit;

  for (genvar i = 0; i < N; i++) begin : g_a
    for (genvar j = 0; j < N; j++) begin : g_b
      // register 0 never creates a dependency
      assign pair_hit[i*N+j] = (a_i[i] == b_i[j]) && (a_i[i] != '0);
    end
  end

  assign hit_o = |pair_hit;
endmodule

// File: rtl/swap_decider.sv
module swap_decider #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 6,
  parameter int unsigned OFF_W  = 3
) (
  input  logic [ADDR_W-1:0]                                  p_pc_i,
  input  logic                                               p_jump_i,
  input  logic                                               p_tgt_i,
  input  logic                                               p_mark_i,
  input  logic [jump_swap_pkg::REGS_PER_INSN-1:0][REG_W-1:0] p_regs_i,
  input  logic [ADDR_W-1:0]                                  s_pc_i,
  input  logic                                               s_jump_i,
  input  logic                                               s_tgt_i,
  input  logic                                               s_mark_i,
  input  logic [jump_swap_pkg::REGS_PER_INSN-1:0][REG_W-1:0] s_regs_i,
  output logic                                               swap_o
);
  import jump_swap_pkg::*;

  logic      reg_hit;
  swap_why_e why;

  reg_overlap #(.REG_W(REG_W)) u_overlap (
    .a_i  (p_regs_i),
    .b_i  (s_regs_i),
    .hit_o(reg_hit)
  );

  always_comb begin
    if (!s_jump_i)                                          why = SW_NOT_JUMP;
    else if (p_jump_i)                                      why = SW_PRED_JUMP;
    else if (p_tgt_i || s_tgt_i)                            why = SW_TARGET;
    else if (p_mark_i || s_mark_i)                          why = SW_MARKED;
    else if (p_pc_i[ADDR_W-1:OFF_W] != s_pc_i[ADDR_W-1:OFF_W]) why = SW_LINE;
    else if (reg_hit)                                       why = SW_REGS;
    else                                                    why = SW_OK;
  end

  assign swap_o = (why == SW_OK);
endmodule

// File: rtl/rewrite_req.sv
module rewrite_req #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] lo_pc_i,
  input  logic [WORD_W-1:0] lo_word_i,
  input  logic [ADDR_W-1:0] hi_pc_i,
  input  logic [WORD_W-1:0] hi_word_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_pc_lo_o,
  output logic [WORD_W-1:0] wr_word_lo_o,
  output logic [ADDR_W-1:0] wr_pc_hi_o,
  output logic [WORD_W-1:0] wr_word_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o   <= 1'b0;
      wr_pc_lo_o   <= '0;
      wr_word_lo_o <= '0;
      wr_pc_hi_o   <= '0;
      wr_word_hi_o <= '0;
    end else begin
      wr_valid_o <= fire_i;
      if (fire_i) begin
        wr_pc_lo_o   <= lo_pc_i;
        wr_word_lo_o <= lo_word_i;
        wr_pc_hi_o   <= hi_pc_i;
        wr_word_hi_o <= hi_word_i;
      end
    end
  end

  // R9
  wb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
endmodule

// File: rtl/jump_swap_stage.sv
module jump_swap_stage #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned REG_W      = 6,
  parameter int unsigned LINE_WORDS = 8,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned WORD_W    = 2 + 3*REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_pc_i,
  input  logic              in_jump_i,
  input  logic              in_tgt_i,
  input  logic              in_mark_i,
  input  logic [REG_W-1:0]  in_rs1_i,
  input  logic [REG_W-1:0]  in_rs2_i,
  input  logic [REG_W-1:0]  in_rd_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_pc_o,
  output logic              out_jump_o,
  output logic              out_tgt_o,
  output logic              out_mark_o,
  output logic [REG_W-1:0]  out_rs1_o,
  output logic [REG_W-1:0]  out_rs2_o,
  output logic [REG_W-1:0]  out_rd_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_pc_lo_o,
  output logic [WORD_W-1:0] wr_word_lo_o,
  output logic [ADDR_W-1:0] wr_pc_hi_o,
  output logic [WORD_W-1:0] wr_word_hi_o
);
  import jump_swap_pkg::*;

  logic                                h_vld_q;
  logic [ADDR_W-1:0]                   h_pc_q;
  logic                                h_jump_q, h_tgt_q, h_mark_q;
  logic [REGS_PER_INSN-1:0][REG_W-1:0] h_regs_q;
  logic [REGS_PER_INSN-1:0][REG_W-1:0] in_regs;
  logic                                swap, hs;

  assign in_regs = {in_rd_i, in_rs2_i, in_rs1_i};

  swap_decider #(.ADDR_W(ADDR_W), .REG_W(REG_W), .OFF_W(OFF_W)) u_decider (
    .p_pc_i  (h_pc_q),
    .p_jump_i(h_jump_q),
    .p_tgt_i (h_tgt_q),
    .p_mark_i(h_mark_q),
    .p_regs_i(h_regs_q),
    .s_pc_i  (in_pc_i),
    .s_jump_i(in_jump_i),
    .s_tgt_i (in_tgt_i),
    .s_mark_i(in_mark_i),
    .s_regs_i(in_regs),
    .swap_o  (swap)
  );

  assign in_ready_o  = !h_vld_q || out_ready_i;
  assign out_valid_o = h_vld_q && in_valid_i;
  assign hs          = in_valid_i && in_ready_o;

  // jump overtakes the held instruction and takes its slot
  always_comb begin
    if (swap) begin
      out_pc_o   = h_pc_q;
      out_jump_o = in_jump_i;
      out_tgt_o  = in_tgt_i;
      out_mark_o = 1'b1;
      out_rs1_o  = in_rs1_i;
      out_rs2_o  = in_rs2_i;
      out_rd_o   = in_rd_i;
    end else begin
      out_pc_o   = h_pc_q;
      out_jump_o = h_jump_q;
      out_tgt_o  = h_tgt_q;
      out_mark_o = h_mark_q;
      out_rs1_o  = h_regs_q[0];
      out_rs2_o  = h_regs_q[1];
      out_rd_o   = h_regs_q[2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_vld_q  <= 1'b0;
      h_pc_q   <= '0;
      h_jump_q <= 1'b0;
      h_tgt_q  <= 1'b0;
      h_mark_q <= 1'b0;
      h_regs_q <= '0;
    end else if (hs) begin
      h_vld_q <= 1'b1;
      if (h_vld_q && swap) begin
        h_pc_q   <= in_pc_i;
        h_mark_q <= 1'b1;
      end else begin
        h_pc_q   <= in_pc_i;
        h_jump_q <= in_jump_i;
        h_tgt_q  <= in_tgt_i;
        h_mark_q <= in_mark_i;
        h_regs_q <= in_regs;
      end
    end
  end

  rewrite_req #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rewrite (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (hs && h_vld_q && swap),
    .lo_pc_i     (h_pc_q),
    .lo_word_i   ({1'b1, in_jump_i, in_rs1_i, in_rs2_i, in_rd_i}),
    .hi_pc_i     (in_pc_i),
    .hi_word_i   ({1'b1, h_jump_q, h_regs_q[0], h_regs_q[1], h_regs_q[2]}),
    .wr_valid_o  (wr_valid_o),
    .wr_pc_lo_o  (wr_pc_lo_o),
    .wr_word_lo_o(wr_word_lo_o),
    .wr_pc_hi_o  (wr_pc_hi_o),
    .wr_word_hi_o(wr_word_hi_o)
  );

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_vld_q && !out_ready_i) |=> (h_vld_q && $stable(h_pc_q) && $stable(h_regs_q)
                                   && $stable(h_jump_q) && $stable(h_mark_q)));
  // R9
  wb_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_word_lo_o[WORD_W-2] && !wr_word_hi_o[WORD_W-2]));
  // R6
  wb_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_pc_lo_o[ADDR_W-1:OFF_W] == wr_pc_hi_o[ADDR_W-1:OFF_W]));
  // R8
  held_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (h_vld_q && h_mark_q && (h_pc_q == wr_pc_hi_o)));
endmodule

// File: tb/jump_swap_stage_tb.sv
`timescale 1ns/1ps
module jump_swap_stage_tb;
  localparam int AW = 16;
  localparam int RW = 6;
  localparam int WW = 2 + 3*RW;

  typedef struct packed {
    logic [AW-1:0] pc;
    logic jump, tgt, mark;
    logic [RW-1:0] rs1, rs2, rd;
  } d_t;

  logic clk = 0, rst_ni = 0;
  always #10 clk = ~clk;

  logic in_valid, in_ready, out_valid, out_ready;
  d_t   din;
  logic [AW-1:0] out_pc, wr_pc_lo, wr_pc_hi;
  logic out_jump, out_tgt, out_mark, wr_valid;
  logic [RW-1:0] out_rs1, out_rs2, out_rd;
  logic [WW-1:0] wr_word_lo, wr_word_hi;

  jump_swap_stage u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_pc_i(din.pc), .in_jump_i(din.jump), .in_tgt_i(din.tgt), .in_mark_i(din.mark),
    .in_rs1_i(din.rs1), .in_rs2_i(din.rs2), .in_rd_i(din.rd),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_pc_o(out_pc), .out_jump_o(out_jump), .out_tgt_o(out_tgt), .out_mark_o(out_mark),
    .out_rs1_o(out_rs1), .out_rs2_o(out_rs2), .out_rd_o(out_rd),
    .wr_valid_o(wr_valid), .wr_pc_lo_o(wr_pc_lo), .wr_word_lo_o(wr_word_lo),
    .wr_pc_hi_o(wr_pc_hi), .wr_word_hi_o(wr_word_hi)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_hv = 0;
  d_t m_h;
  bit m_wv = 0;
  logic [AW-1:0] m_wpl, m_wph;
  logic [WW-1:0] m_wwl, m_wwh;

  function automatic logic [WW-1:0] pack(d_t d);
    return {1'b1, d.jump, d.rs1, d.rs2, d.rd};
  endfunction

  function automatic bit share(d_t a, d_t b);
    logic [2:0][RW-1:0] ra, rb;
    ra = {a.rd, a.rs2, a.rs1};
    rb = {b.rd, b.rs2, b.rs1};
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        if (ra[i] != 0 && ra[i] == rb[j]) return 1;
    return 0;
  endfunction

  function automatic bit may_swap(d_t p, d_t s);
    return s.jump && !p.jump && !p.tgt && !s.tgt && !p.mark && !s.mark &&
           (p.pc[AW-1:3] == s.pc[AW-1:3]) && !share(p, s);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, check mid-low-phase, advance model at the coming edge
  task automatic step(bit iv, bit ordy, d_t d, string tag);
    d_t eo;
    bit sw;
    @(negedge clk);
    in_valid = iv; out_ready = ordy; din = d;
    #5;
    chk("R10", "in_ready", in_ready, !m_hv || ordy);
    chk("R2", "out_valid", out_valid, m_hv && iv);
    sw = m_hv && may_swap(m_h, d);
    if (m_hv && iv) begin
      if (sw) begin eo = d; eo.pc = m_h.pc; eo.mark = 1; end
      else eo = m_h;
      chk(tag, "out", {out_pc, out_jump, out_tgt, out_mark, out_rs1, out_rs2, out_rd}, eo);
    end
    chk("R9", "wr_valid", wr_valid, m_wv);
    if (m_wv)
      chk("R9", "wr_data", {wr_pc_lo, wr_word_lo, wr_pc_hi, wr_word_hi},
          {m_wpl, m_wwl, m_wph, m_wwh});
    m_wv = 0;
    if (iv && (!m_hv || ordy)) begin
      if (sw) begin
        m_wv = 1; m_wpl = m_h.pc; m_wwl = pack(d); m_wph = d.pc; m_wwh = pack(m_h);
        m_h.pc = d.pc; m_h.mark = 1;
      end else m_h = d;
      m_hv = 1;
    end
  endtask

  function automatic d_t mk(int pc, bit j, bit t, bit m, int a, int b, int c);
    d_t d;
    d.pc = pc[AW-1:0]; d.jump = j; d.tgt = t; d.mark = m;
    d.rs1 = a[RW-1:0]; d.rs2 = b[RW-1:0]; d.rd = c[RW-1:0];
    return d;
  endfunction

  task automatic pair(d_t p, d_t j, string tag);
    step(1, 1, p, tag);
    step(1, 1, j, tag);
    step(1, 1, mk(j.pc + 1, 0, 0, 1, 0, 0, 0), tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    d_t cur;
    int pc = 100;
    void'($urandom(32'd7));
    in_valid = 0; out_ready = 0; din = '0;
    #25;
    chk("R1", "reset out_valid", out_valid, 0);
    chk("R1", "reset wr_valid", wr_valid, 0);
    chk("R1", "reset in_ready", in_ready, 1);
    @(negedge clk); rst_ni = 1;
    #5;
    chk("R1", "post-reset out_valid", out_valid, 0);
    chk("R1", "post-reset in_ready", in_ready, 1);

    pair(mk('h20, 0, 0, 0, 1, 2, 3), mk('h21, 1, 0, 0, 4, 5, 6), "R3");
    pair(mk('h30, 0, 0, 0, 1, 2, 3), mk('h31, 1, 0, 0, 3, 0, 0), "R5");
    pair(mk('h40, 0, 0, 0, 0, 2, 3), mk('h41, 1, 0, 0, 0, 4, 0), "R5");
    pair(mk('h4f, 0, 0, 0, 1, 2, 3), mk('h50, 1, 0, 0, 4, 5, 6), "R6");
    pair(mk('h60, 0, 1, 0, 1, 2, 3), mk('h61, 1, 0, 0, 4, 5, 6), "R7");
    pair(mk('h70, 0, 0, 0, 1, 2, 3), mk('h71, 1, 1, 0, 4, 5, 6), "R7");
    pair(mk('h80, 0, 0, 0, 1, 2, 3), mk('h81, 1, 0, 1, 4, 5, 6), "R8");
    pair(mk('h90, 1, 0, 0, 1, 2, 3), mk('h91, 1, 0, 0, 4, 5, 6), "R4");
    // stall with a swappable pair pending
    step(1, 1, mk('hA0, 0, 0, 0, 1, 2, 3), "R10");
    for (int k = 0; k < 4; k++) step(1, 0, mk('hA1, 1, 0, 0, 4, 5, 6), "R10");
    step(1, 1, mk('hA1, 1, 0, 0, 4, 5, 6), "R10");
    step(1, 1, mk('hA2, 0, 0, 1, 0, 0, 0), "R10");

    cur = mk(pc, 0, 0, 0, 1, 2, 3);
    for (int n = 0; n < 4000; n++) begin
      bit iv = ($urandom % 4) != 0;
      bit rd = ($urandom % 4) != 0;
      bit acc = iv && (!m_hv || rd);
      step(iv, rd, cur, "R2/R3");
      if (acc) begin
        pc += (($urandom % 10) == 0) ? 5 : 1;
        cur = mk(pc, ($urandom % 3) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
                 $urandom % 5, $urandom % 5, $urandom % 5);
      end
    end
    step(0, 1, cur, "R9");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule